// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Selectable Write Policy

This block is a direct-mapped cache of 32-bit words. It sits between a processor-side port that issues single-word reads and writes and a backing memory port that moves one word per handshake. The number of lines (`SETS`) and the number of words in each line (`WORDS`) are parameters, and both must be powers of two. Each line holds a valid flag, a dirty flag and a tag. On a miss the whole line is refilled from memory. A write that misses first refills the line and then merges the written word into it.

A level input selects the write policy while the block runs. In write-through mode every processor write also goes to memory at once. In write-back mode a write only marks the line dirty, and dirty lines reach memory when they are displaced or when a flush runs. A flush command walks every line, writes back the dirty ones in write-back mode and leaves the whole cache invalid. Two counters record hits and misses.

Top module: `dm_cache`

## Requirements
- R1: After reset both counters read 0, `cpu_ready`, `flush_done` and `mem_req` are low, and every line is invalid, so the first access to any address is a miss.
- R2: Byte addresses are word aligned (bits 1:0 are zero). The word address `w = addr >> 2` is split into three parts: column = `w % WORDS`, line index = `(w / WORDS) % SETS`, tag = `w / (SETS*WORDS)`.
- R3: An access hits only when the indexed line is valid and its stored tag equals the request tag. A read hit returns the stored word with no memory traffic. Each access adds exactly one to `hit_count` or to `miss_count`.
- R4: A read miss fetches all `WORDS` words of the line in ascending order. The fetch starts at the line-aligned byte address and steps by 4. The requested word is returned when the fill ends.
- R5: In write-through mode (`wb_mode`=0) each processor write updates the cache and issues exactly one memory write of the same word to the same address.
- R6: In write-back mode (`wb_mode`=1) a write sets the line's dirty flag and issues no memory write of its own. Reads leave the dirty flag unchanged.
- R7: When a miss displaces a valid line that is dirty while `wb_mode`=1, the old line's `WORDS` words are written to the address formed from its stored tag and index before the refill starts. A clean displaced line is dropped without any memory write.
- R8: A write miss refills the line from memory, places the written word at its column and keeps the other fetched words.
- R9: A flush (held `flush_req`, finished by a one-cycle `flush_done`) writes every valid dirty line back when `wb_mode`=1 and then invalidates all lines. With `wb_mode`=0 it writes nothing to memory.
- R10: `cpu_req` and its fields are held until `cpu_ready` pulses for one cycle, and `cpu_rdata` is valid in that cycle. `mem_req` and its fields are held until `mem_ack` pulses for one cycle, and for a read `mem_rdata` is valid in the cycle of that pulse.
- R11: From reset in write-through mode, the access sequence 0x200, 0x204, 0x21C, 0x300 (reads, done twice) followed by two writes to 0x700 gives hits/misses of 4/6 for 4 lines × 4 words, 3/7 for 8 × 1 and 5/5 for 1 × 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle pulse when a flush ends |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
A hit completes two edges after the request is taken: the lookup edge and the response cycle. A miss adds one memory handshake per fetched word, plus `WORDS` more handshakes for a dirty eviction and one more for a write-through forward. Both counters change at the lookup edge, so they are final before `cpu_ready` rises. Because the latency varies, the bench never predicts an edge. It waits, at falling edges, for each access or flush to finish. Only then does it compare the returned word, the counters, the memory model's contents and its count of memory writes against values derived from the address split.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_DONE,
        ST_FSCAN,
        ST_FWB,
        ST_FDONE
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int LOG_W = 2,
    parameter int LOG_S = 2,
    localparam int COL_W = (LOG_W > 0) ? LOG_W : 1,
    localparam int IDX_W = (LOG_S > 0) ? LOG_S : 1,
    localparam int TAG_W = 30 - LOG_W - LOG_S
) (
    input  logic [29:0]      waddr,
    output logic [COL_W-1:0] col,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    generate
        if (LOG_W > 0) begin : g_col
            assign col = waddr[LOG_W-1:0];
        end else begin : g_nocol
            assign col = '0;
        end
        if (LOG_S > 0) begin : g_idx
            assign idx = waddr[LOG_W +: LOG_S];
        end else begin : g_noidx
            assign idx = '0;
        end
    endgenerate
    assign tag = waddr[29 -: TAG_W];
endmodule

// File: rtl/dmc_addr_join.sv
module dmc_addr_join #(
    parameter int LOG_W = 2,
    parameter int LOG_S = 2,
    localparam int COL_W = (LOG_W > 0) ? LOG_W : 1,
    localparam int IDX_W = (LOG_S > 0) ? LOG_S : 1,
    localparam int TAG_W = 30 - LOG_W - LOG_S
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [IDX_W-1:0] idx,
    input  logic [COL_W-1:0] col,
    output logic [31:0]      addr
);
    // Unused idx/col bits are constant zero when a dimension has one entry.
    assign addr = ((32'(tag) << (LOG_S + LOG_W)) | (32'(idx) << LOG_W) | 32'(col)) << 2;
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int SETS  = 4,
    parameter int WORDS = 4,
    parameter int COL_W = 2,
    parameter int IDX_W = 2,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [COL_W-1:0] rd_col,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [31:0]      rd_word,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [COL_W-1:0] wr_col,
    input  logic [31:0]      wr_data,
    input  logic             meta_en,
    input  logic [IDX_W-1:0] meta_idx,
    input  logic             meta_valid,
    input  logic             meta_dirty,
    input  logic [TAG_W-1:0] meta_tag
);
    logic [31:0]      data_q [SETS][WORDS];
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_word  = data_q[rd_idx][rd_col];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx][wr_col] <= wr_data;
        if (meta_en) tag_q[meta_idx] <= meta_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (meta_en) begin
            valid_q[meta_idx] <= meta_valid;
            dirty_q[meta_idx] <= meta_dirty;
        end
    end
endmodule

// File: rtl/dm_cache.sv
module dm_cache
    import dmc_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WORDS = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_mode,
    input  logic             flush_req,
    output logic             flush_done,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [31:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic             cpu_ready,
    output logic [31:0]      cpu_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int LOG_W = $clog2(WORDS);
    localparam int LOG_S = $clog2(SETS);
    localparam int COL_W = (LOG_W > 0) ? LOG_W : 1;
    localparam int IDX_W = (LOG_S > 0) ? LOG_S : 1;
    localparam int TAG_W = 30 - LOG_W - LOG_S;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SETS - 1);

    typedef struct packed {
        dmc_state_e       st;
        logic [31:0]      addr;
        logic             we;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
        logic [COL_W-1:0] cnt;
        logic [IDX_W-1:0] fidx;
        logic [TAG_W-1:0] vtag;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } regs_t;

    regs_t q, d;

    // address split for the incoming and the held request
    logic [COL_W-1:0] c_col, r_col;
    logic [IDX_W-1:0] c_idx, r_idx;
    logic [TAG_W-1:0] c_tag, r_tag;

    dmc_addr_split #(.LOG_W(LOG_W), .LOG_S(LOG_S)) u_split_cpu (
        .waddr(cpu_addr[31:2]), .col(c_col), .idx(c_idx), .tag(c_tag));
    dmc_addr_split #(.LOG_W(LOG_W), .LOG_S(LOG_S)) u_split_req (
        .waddr(q.addr[31:2]), .col(r_col), .idx(r_idx), .tag(r_tag));

    // line store
    logic [IDX_W-1:0] rd_idx, wr_idx, meta_idx;
    logic [COL_W-1:0] rd_col, wr_col;
    logic             rd_valid, rd_dirty, wr_en, meta_en, meta_valid, meta_dirty;
    logic [TAG_W-1:0] rd_tag, meta_tag;
    logic [31:0]      rd_word, wr_data;

    dmc_line_store #(.SETS(SETS), .WORDS(WORDS), .COL_W(COL_W), .IDX_W(IDX_W),
                     .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_col(rd_col), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_word(rd_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_col(wr_col), .wr_data(wr_data),
        .meta_en(meta_en), .meta_idx(meta_idx), .meta_valid(meta_valid),
        .meta_dirty(meta_dirty), .meta_tag(meta_tag));

    // memory address composition
    logic [TAG_W-1:0] j_tag;
    logic [IDX_W-1:0] j_idx;
    logic [COL_W-1:0] j_col;
    logic [31:0]      j_addr;

    dmc_addr_join #(.LOG_W(LOG_W), .LOG_S(LOG_S)) u_join (
        .tag(j_tag), .idx(j_idx), .col(j_col), .addr(j_addr));

    logic flush_st;
    assign flush_st = (q.st == ST_FSCAN) || (q.st == ST_FWB);

    always_comb begin
        d          = q;
        rd_idx     = (q.st == ST_IDLE) ? c_idx : (flush_st ? q.fidx : r_idx);
        rd_col     = (q.st == ST_IDLE) ? c_col :
                     ((q.st == ST_EVICT) || (q.st == ST_FWB)) ? q.cnt : r_col;
        wr_en      = 1'b0;
        wr_idx     = r_idx;
        wr_col     = q.cnt;
        wr_data    = mem_rdata;
        meta_en    = 1'b0;
        meta_idx   = r_idx;
        meta_valid = 1'b0;
        meta_dirty = 1'b0;
        meta_tag   = r_tag;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = rd_word;
        j_tag      = r_tag;
        j_idx      = r_idx;
        j_col      = q.cnt;

        unique case (q.st)
            ST_IDLE: begin
                if (flush_req) begin
                    d.st   = ST_FSCAN;
                    d.fidx = '0;
                    d.cnt  = '0;
                end else if (cpu_req) begin
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    d.cnt   = '0;
                    if (rd_valid && (rd_tag == c_tag)) begin
                        d.hits = q.hits + 1'b1;
                        if (cpu_we) begin
                            wr_en   = 1'b1;
                            wr_idx  = c_idx;
                            wr_col  = c_col;
                            wr_data = cpu_wdata;
                            if (wb_mode) begin
                                meta_en    = 1'b1;
                                meta_idx   = c_idx;
                                meta_valid = 1'b1;
                                meta_dirty = 1'b1;
                                meta_tag   = c_tag;
                            end
                            d.st = wb_mode ? ST_DONE : ST_WTHRU;
                        end else begin
                            d.rdata = rd_word;
                            d.st    = ST_DONE;
                        end
                    end else begin
                        d.misses = q.misses + 1'b1;
                        d.vtag   = rd_tag;
                        if (rd_valid && rd_dirty && wb_mode) begin
                            d.st = ST_EVICT;
                        end else begin
                            meta_en  = 1'b1;
                            meta_idx = c_idx;
                            meta_tag = c_tag;
                            d.st     = ST_FILL;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                j_tag   = q.vtag;
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == COL_LAST) begin
                        d.cnt   = '0;
                        meta_en = 1'b1;
                        d.st    = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en   = 1'b1;
                    wr_data = (q.we && (q.cnt == r_col)) ? q.wdata : mem_rdata;
                    if (!q.we && (q.cnt == r_col)) d.rdata = mem_rdata;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == COL_LAST) begin
                        meta_en    = 1'b1;
                        meta_valid = 1'b1;
                        meta_dirty = q.we && wb_mode;
                        d.st       = (q.we && !wb_mode) ? ST_WTHRU : ST_DONE;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = q.wdata;
                j_col     = r_col;
                if (mem_ack) d.st = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            ST_FSCAN: begin
                if (wb_mode && rd_valid && rd_dirty) begin
                    d.st  = ST_FWB;
                    d.cnt = '0;
                end else begin
                    meta_en  = 1'b1;
                    meta_idx = q.fidx;
                    meta_tag = rd_tag;
                    d.fidx   = q.fidx + 1'b1;
                    if (q.fidx == IDX_LAST) d.st = ST_FDONE;
                end
            end
            ST_FWB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                j_tag   = rd_tag;
                j_idx   = q.fidx;
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == COL_LAST) begin
                        meta_en  = 1'b1;
                        meta_idx = q.fidx;
                        meta_tag = rd_tag;
                        d.fidx   = q.fidx + 1'b1;
                        d.st     = (q.fidx == IDX_LAST) ? ST_FDONE : ST_FSCAN;
                    end
                end
            end
            ST_FDONE: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr   = j_addr;
    assign cpu_ready  = (q.st == ST_DONE);
    assign flush_done = (q.st == ST_FDONE);
    assign cpu_rdata  = q.rdata;
    assign hit_count  = q.hits;
    assign miss_count = q.misses;

    // R2: requests carry word-aligned byte addresses
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[1:0] == 2'b00));

    // R3: one access never bumps both counters in the same edge
    a_r3_one_count: assert property (@(posedge clk) disable iff (!rst_n)
        !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

    // R4: every memory read belongs to the line of the held request
    a_r4_fill_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ((mem_addr >> (LOG_W + 2)) == (q.addr >> (LOG_W + 2))));

    // R4: a completed access leaves its line valid with the request's tag
    a_r4_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (rd_valid && (rd_tag == r_tag)));

    // R5: a write-through write completes only after a memory write was acknowledged
    a_r5_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && q.we && !wb_mode) |-> $past(mem_ack && mem_we));

    // R10: memory request and its fields hold until acknowledged
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: completion is a single-cycle pulse
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
endmodule

// File: tb/dm_cache_bench.sv
module dmc_lane #(
    parameter int SETS  = 4,
    parameter int WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wb_mode,
    input  logic        go,
    input  logic        fgo,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    input  logic        pl_en,
    input  logic [9:0]  pl_addr,
    input  logic [31:0] pl_data,
    output logic        busy,
    output logic [31:0] rdata,
    output logic [31:0] hits,
    output logic [31:0] misses,
    output logic [31:0] wr_cnt
);
    logic        creq, freq, cpu_ready, flush_done;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] mem [0:1023];

    dm_cache #(.SETS(SETS), .WORDS(WORDS), .CNT_W(32)) u_dm_cache (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .flush_req(freq), .flush_done(flush_done),
        .cpu_req(creq), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_count(hits), .miss_count(misses));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            creq  <= 1'b0;
            freq  <= 1'b0;
            rdata <= '0;
        end else begin
            if (go) creq <= 1'b1;
            else if (cpu_ready) begin
                creq  <= 1'b0;
                rdata <= cpu_rdata;
            end
            if (fgo) freq <= 1'b1;
            else if (flush_done) freq <= 1'b0;
        end
    end
    assign busy = creq | freq | go | fgo;

    always_ff @(posedge clk) begin
        if (pl_en) mem[pl_addr] <= pl_data;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wr_cnt  <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end
        end
    end
endmodule

module dm_cache_bench;
    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } vec_t;

    // reads carry the expected word, writes carry the word written
    localparam vec_t VEC [10] = '{
        '{1'b0, 32'h200, 32'h24}, '{1'b0, 32'h204, 32'h66},
        '{1'b0, 32'h21C, 32'h12}, '{1'b0, 32'h300, 32'h32},
        '{1'b0, 32'h200, 32'h24}, '{1'b0, 32'h204, 32'h66},
        '{1'b0, 32'h21C, 32'h12}, '{1'b0, 32'h300, 32'h32},
        '{1'b1, 32'h700, 32'h24}, '{1'b1, 32'h700, 32'h23}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b0;
    logic        go = 1'b0, fgo = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic        pl_en = 1'b0;
    logic [9:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic        b0, b1, b2;
    logic [31:0] rd0, rd1, rd2, h0, h1, h2, m0, m1, m2, w0, w1, w2;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    dmc_lane #(.SETS(4), .WORDS(4)) u_l0 (.clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .go(go), .fgo(fgo), .we(we), .addr(addr), .wdata(wdata), .pl_en(pl_en),
        .pl_addr(pl_addr), .pl_data(pl_data), .busy(b0), .rdata(rd0), .hits(h0),
        .misses(m0), .wr_cnt(w0));
    dmc_lane #(.SETS(8), .WORDS(1)) u_l1 (.clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .go(go), .fgo(fgo), .we(we), .addr(addr), .wdata(wdata), .pl_en(pl_en),
        .pl_addr(pl_addr), .pl_data(pl_data), .busy(b1), .rdata(rd1), .hits(h1),
        .misses(m1), .wr_cnt(w1));
    dmc_lane #(.SETS(1), .WORDS(8)) u_l2 (.clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .go(go), .fgo(fgo), .we(we), .addr(addr), .wdata(wdata), .pl_en(pl_en),
        .pl_addr(pl_addr), .pl_data(pl_data), .busy(b2), .rdata(rd2), .hits(h2),
        .misses(m2), .wr_cnt(w2));

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return {16'hA5A5, a[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        int n = 0;
        while ((b0 || b1 || b2) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check("R10 completion timeout", 32'd1, 32'd0);
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] dat);
        @(negedge clk);
        we = w; addr = a; wdata = dat; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        settle();
    endtask

    task automatic flush();
        @(negedge clk);
        fgo = 1'b1;
        @(negedge clk);
        fgo = 1'b0;
        settle();
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hb, mb, wb;
        // preload memory with an address pattern plus the sequence's words
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            pl_en   = 1'b1;
            pl_addr = 10'(i);
            case (i)
                32'h200 >> 2: pl_data = 32'h24;
                32'h204 >> 2: pl_data = 32'h66;
                32'h21C >> 2: pl_data = 32'h12;
                32'h300 >> 2: pl_data = 32'h32;
                default:      pl_data = pattern(32'(i) << 2);
            endcase
        end
        @(negedge clk);
        pl_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 hits l0", h0, 0);   check("R1 misses l0", m0, 0);
        check("R1 hits l1", h1, 0);   check("R1 misses l2", m2, 0);
        check("R1 idle l0", 32'(b0), 0);
        check("R1 no mem writes", w0 + w1 + w2, 0);

        // table walk: R3 R4 R5 across three geometries
        foreach (VEC[k]) begin
            access(VEC[k].we, VEC[k].addr, VEC[k].data);
            if (!VEC[k].we) begin
                check("R4 read data 4x4", rd0, VEC[k].data);
                check("R4 read data 8x1", rd1, VEC[k].data);
                check("R4 read data 1x8", rd2, VEC[k].data);
            end else begin
                check("R5 forwarded 4x4", u_l0.mem[VEC[k].addr[11:2]], VEC[k].data);
                check("R5 forwarded 8x1", u_l1.mem[VEC[k].addr[11:2]], VEC[k].data);
                check("R5 forwarded 1x8", u_l2.mem[VEC[k].addr[11:2]], VEC[k].data);
            end
        end
        check("R5 one write each 4x4", w0, 2);
        check("R5 one write each 1x8", w2, 2);
        // R11 / R2 reference counts, R1 first access misses
        check("R11 hits 4x4", h0, 4);   check("R11 misses 4x4", m0, 6);
        check("R11 hits 8x1", h1, 3);   check("R11 misses 8x1", m1, 7);
        check("R11 hits 1x8", h2, 5);   check("R11 misses 1x8", m2, 5);

        // R9 write-through flush writes nothing, then lines are invalid
        wb = w0;
        flush();
        check("R9 wt flush no writes", w0, wb);
        mb = m0;
        access(1'b0, 32'h204, 0);
        check("R9 miss after flush", m0, mb + 1);
        check("R4 refill data", rd0, 32'h66);

        // R6 R8 write-back write miss merges and stays in cache
        wb_mode = 1'b1;
        wb = w0; hb = h0;
        access(1'b1, 32'h708, 32'h55);
        check("R6 no forward", w0, wb);
        check("R6 memory untouched", u_l0.mem[32'h708 >> 2], pattern(32'h708));
        access(1'b0, 32'h708, 0);
        check("R8 merged word", rd0, 32'h55);
        access(1'b0, 32'h704, 0);
        check("R8 fetched neighbour", rd0, pattern(32'h704));
        check("R3 two hits", h0, hb + 2);

        // R7 dirty eviction writes old line at its own address
        access(1'b0, 32'h300, 0);
        check("R7 evict count", w0, wb + 4);
        check("R7 evicted word", u_l0.mem[32'h708 >> 2], 32'h55);
        check("R7 evicted neighbour", u_l0.mem[32'h700 >> 2], 32'h23);
        check("R4 data after evict", rd0, 32'h32);
        wb = w0;
        access(1'b0, 32'h200, 0);
        check("R7 clean drop", w0, wb);

        // R9 write-back flush
        access(1'b1, 32'h214, 32'h77);
        access(1'b1, 32'h224, 32'h88);
        check("R6 still no forward", w0, wb);
        flush();
        check("R9 wb flush count", w0, wb + 8);
        check("R9 flushed word a", u_l0.mem[32'h214 >> 2], 32'h77);
        check("R9 flushed word b", u_l0.mem[32'h224 >> 2], 32'h88);
        mb = m0;
        access(1'b0, 32'h214, 0);
        check("R9 invalid after flush", m0, mb + 1);
        check("R9 data after flush", rd0, 32'h77);

        // R1 reset again clears counters
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hits after reset", h0, 0);
        check("R1 misses after reset", m0, 0);
        mb = m0;
        access(1'b0, 32'h214, 0);
        check("R1 first access misses", m0, mb + 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule